// File: doc/BRIEF.md
# Hardware Counting Semaphore

The block is one counting semaphore shared by several requesters, for example processor cores or hardware task engines. Each requester has its own command lane. A command is either an acquire, which takes one unit, or a release, which gives one unit back. A round-robin arbiter accepts at most one command per clock. The count update and the update of the wait queue happen together in that single clock edge, so no other command can slip between the read of the count and its write-back.

The count is signed. When it is negative, its magnitude is the number of requesters that are parked in a first-in first-out wait queue. An acquire that takes the count below zero is answered as blocked, and the requester's ID goes into the queue. A release that leaves the count at zero or below pops the oldest waiter and sends a one-cycle wake pulse carrying that waiter's ID. An acquire issued when every requester is already waiting is refused: the count stays where it is, nothing is queued, and an error pulse goes out with the response.

Top module: `csem_unit`

## Requirements
- R1: Synchronous reset, active high, loads the count from parameter INIT_COUNT and empties the wait queue. It also clears rsp_valid, wake_valid and ovf_err. After reset, no ID that was queued before it is ever woken.
- R2: An acquire (cmd_up=0) accepted while the count is positive lowers the count by one. It is answered with rsp_blocked=0.
- R3: An acquire accepted while the count is zero or negative, but above -N_REQ, lowers the count by one. It is answered with rsp_blocked=1, and the requester's ID is appended to the tail of the wait queue.
- R4: A release (cmd_up=1) raises the count by one. If the new count is zero or below, wake_valid pulses for exactly one cycle, and wake_id holds the oldest queued ID (first-in first-out order).
- R5: A release that leaves the count above zero raises wake_valid for no cycle.
- R6: cmd_ready is one-hot or zero. It is only ever set on a lane whose cmd_valid is high, so at most one command is accepted per clock.
- R7: When several lanes are valid, grant goes to the first valid lane found by scanning upward, with wrap-around, from the lane after the last one granted. After reset the scan starts at lane 0.
- R8: An acquire accepted while the count equals -N_REQ leaves the count and the queue unchanged. It is answered with rsp_blocked=0 and ovf_err=1 for one cycle.
- R9: A command accepted on lane i at a clock edge is answered during the following cycle. In that cycle rsp_valid is one-hot with bit i set, and rsp_blocked, ovf_err, wake_valid, wake_id and count_o all show the result of that command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | N_REQ | Per-lane command request |
| cmd_up | input | N_REQ | Per-lane operation: 1 release, 0 acquire |
| cmd_ready | output | N_REQ | Per-lane acceptance (one-hot or zero) |
| rsp_valid | output | N_REQ | Per-lane response strobe, one cycle |
| rsp_blocked | output | 1 | Acquire was queued |
| ovf_err | output | 1 | Acquire refused because the queue is full |
| wake_valid | output | 1 | A waiter is released this cycle |
| wake_id | output | max(1,clog2(N_REQ)) | ID of the released waiter |
| count_o | output | CNT_W | Current signed count |

## Verification
cmd_ready is combinational from cmd_valid and the arbiter pointer. The bench therefore reads it 1 ns after the inputs change in the same cycle. Every other result passes through exactly one register. It becomes visible after the edge that accepts the command, so the bench drives on a falling edge and reads the response at the next falling edge, which is one edge later and half a period clear of it. For the held-request arbitration test the bench drops each lane only after that lane's response has been read, so every grant and its response are checked in adjacent cycles.

// File: rtl/csem_pkg.sv
package csem_pkg;

    typedef enum logic {
        OP_DOWN = 1'b0,
        OP_UP   = 1'b1
    } sem_op_e;

    typedef struct packed {
        logic enq;
        logic deq;
        logic ovf;
    } sem_act_t;

    function automatic int id_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic bit is_pow2(input int n);
        return (n > 0) && ((n & (n - 1)) == 0);
    endfunction

    function automatic sem_act_t sem_decide(input sem_op_e op,
                                            input logic at_floor,
                                            input logic dec_neg,
                                            input logic inc_nonpos);
        sem_act_t a;
        a = '0;
        if (op == OP_DOWN) begin
            if (at_floor)     a.ovf = 1'b1;
            else if (dec_neg) a.enq = 1'b1;
        end else if (inc_nonpos) begin
            a.deq = 1'b1;
        end
        return a;
    endfunction

endpackage

// File: rtl/csem_rr_arb.sv
module csem_rr_arb
    import csem_pkg::*;
#(
    parameter int N_REQ = 4,
    localparam int IDW = id_width(N_REQ)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_REQ-1:0] req,
    output logic [N_REQ-1:0] gnt,
    output logic [IDW-1:0]   gnt_id,
    output logic             gnt_any
);

    logic [IDW-1:0] ptr_q;

    always_comb begin
        gnt     = '0;
        gnt_id  = '0;
        gnt_any = 1'b0;
        for (int k = 0; k < N_REQ; k++) begin
            int idx;
            idx = int'(ptr_q) + k;
            if (idx >= N_REQ) idx = idx - N_REQ;
            if (!gnt_any && req[idx]) begin
                gnt_any  = 1'b1;
                gnt[idx] = 1'b1;
                gnt_id   = IDW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (gnt_any) begin
            ptr_q <= (gnt_id == IDW'(N_REQ - 1)) ? '0 : gnt_id + IDW'(1);
        end
    end

    a_r6_grant_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
    a_r6_grant_requested: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);
    a_r7_any_when_req: assert property (@(posedge clk) disable iff (rst)
        (req != '0) |-> gnt_any);

endmodule

// File: rtl/csem_wait_fifo.sv
module csem_wait_fifo
    import csem_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int IDW   = 2,
    localparam int PW   = id_width(DEPTH),
    localparam int OCCW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic [IDW-1:0]  push_id,
    input  logic            pop,
    output logic [IDW-1:0]  head_id,
    output logic [OCCW-1:0] occ
);

    logic [IDW-1:0] mem [DEPTH];
    logic [PW-1:0]  wr_q, rd_q, wr_nx, rd_nx;
    logic [OCCW-1:0] occ_q;

    generate
        if (is_pow2(DEPTH)) begin : g_wrap_free
            assign wr_nx = wr_q + PW'(1);
            assign rd_nx = rd_q + PW'(1);
        end else begin : g_wrap_cmp
            assign wr_nx = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
            assign rd_nx = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            occ_q <= '0;
        end else begin
            if (push) begin
                mem[wr_q] <= push_id;
                wr_q      <= wr_nx;
            end
            if (pop) rd_q <= rd_nx;
            if (push && !pop)      occ_q <= occ_q + OCCW'(1);
            else if (pop && !push) occ_q <= occ_q - OCCW'(1);
        end
    end

    assign head_id = mem[rd_q];
    assign occ     = occ_q;

    a_r3_no_push_full: assert property (@(posedge clk) disable iff (rst)
        push |-> (occ_q != OCCW'(DEPTH)));
    a_r4_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
        pop |-> (occ_q != '0));
    a_r6_single_access: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));

endmodule

// File: rtl/csem_count_core.sv
module csem_count_core
    import csem_pkg::*;
#(
    parameter int N_REQ      = 4,
    parameter int INIT_COUNT = 1,
    parameter int CNT_W      = 8,
    localparam int IDW = id_width(N_REQ)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    op_fire,
    input  sem_op_e                 op_kind,
    input  logic [IDW-1:0]          op_id,
    input  logic [IDW-1:0]          head_id,
    output logic                    push,
    output logic                    pop,
    output logic signed [CNT_W-1:0] count_q,
    output logic                    rsp_fire_q,
    output logic [IDW-1:0]          rsp_id_q,
    output logic                    rsp_blocked_q,
    output logic                    ovf_q,
    output logic                    wake_q,
    output logic [IDW-1:0]          wake_id_q
);

    localparam logic signed [CNT_W-1:0] FLOOR = CNT_W'(-N_REQ);
    localparam logic signed [CNT_W-1:0] INIT  = CNT_W'(INIT_COUNT);

    logic signed [CNT_W-1:0] dec, inc, count_d;
    sem_act_t act;

    always_comb begin
        dec = count_q - CNT_W'(1);
        inc = count_q + CNT_W'(1);
        act = sem_decide(op_kind, count_q == FLOOR, dec[CNT_W-1],
                         inc[CNT_W-1] || (inc == '0));
        push = op_fire && act.enq;
        pop  = op_fire && act.deq;
        count_d = count_q;
        if (op_fire && !act.ovf) begin
            count_d = (op_kind == OP_UP) ? inc : dec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q       <= INIT;
            rsp_fire_q    <= 1'b0;
            rsp_id_q      <= '0;
            rsp_blocked_q <= 1'b0;
            ovf_q         <= 1'b0;
            wake_q        <= 1'b0;
            wake_id_q     <= '0;
        end else begin
            count_q       <= count_d;
            rsp_fire_q    <= op_fire;
            rsp_id_q      <= op_id;
            rsp_blocked_q <= push;
            ovf_q         <= op_fire && act.ovf;
            wake_q        <= pop;
            wake_id_q     <= pop ? head_id : wake_id_q;
        end
    end

    a_r8_floor_held: assert property (@(posedge clk) disable iff (rst)
        count_q >= FLOOR);
    a_r8_refused_no_change: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> (count_q == $past(count_q)));
    a_r4_wake_nonpositive: assert property (@(posedge clk) disable iff (rst)
        wake_q |-> (count_q <= 0));
    a_r3_blocked_negative: assert property (@(posedge clk) disable iff (rst)
        rsp_blocked_q |-> (count_q < 0));
    a_r9_result_with_rsp: assert property (@(posedge clk) disable iff (rst)
        (wake_q || rsp_blocked_q || ovf_q) |-> rsp_fire_q);

endmodule

// File: rtl/csem_unit.sv
module csem_unit
    import csem_pkg::*;
#(
    parameter int N_REQ      = 4,
    parameter int INIT_COUNT = 2,
    parameter int CNT_W      = 8,
    localparam int IDW  = id_width(N_REQ),
    localparam int OCCW = $clog2(N_REQ + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_REQ-1:0]        cmd_valid,
    input  logic [N_REQ-1:0]        cmd_up,
    output logic [N_REQ-1:0]        cmd_ready,
    output logic [N_REQ-1:0]        rsp_valid,
    output logic                    rsp_blocked,
    output logic                    ovf_err,
    output logic                    wake_valid,
    output logic [IDW-1:0]          wake_id,
    output logic signed [CNT_W-1:0] count_o
);

    logic [N_REQ-1:0]        gnt;
    logic [IDW-1:0]          gnt_id, head_id, rsp_id;
    logic                    gnt_any, push, pop, rsp_fire;
    logic [OCCW-1:0]         occ;
    logic signed [CNT_W-1:0] count_q;
    sem_op_e                 op_kind;

    csem_rr_arb #(.N_REQ(N_REQ)) arb_i (
        .clk(clk), .rst(rst), .req(cmd_valid),
        .gnt(gnt), .gnt_id(gnt_id), .gnt_any(gnt_any)
    );

    assign op_kind = cmd_up[gnt_id] ? OP_UP : OP_DOWN;

    csem_count_core #(.N_REQ(N_REQ), .INIT_COUNT(INIT_COUNT), .CNT_W(CNT_W)) core_i (
        .clk(clk), .rst(rst),
        .op_fire(gnt_any), .op_kind(op_kind), .op_id(gnt_id), .head_id(head_id),
        .push(push), .pop(pop), .count_q(count_q),
        .rsp_fire_q(rsp_fire), .rsp_id_q(rsp_id), .rsp_blocked_q(rsp_blocked),
        .ovf_q(ovf_err), .wake_q(wake_valid), .wake_id_q(wake_id)
    );

    csem_wait_fifo #(.DEPTH(N_REQ), .IDW(IDW)) fifo_i (
        .clk(clk), .rst(rst),
        .push(push), .push_id(gnt_id), .pop(pop),
        .head_id(head_id), .occ(occ)
    );

    generate
        for (genvar i = 0; i < N_REQ; i++) begin : g_rsp
            assign rsp_valid[i] = rsp_fire && (rsp_id == IDW'(i));
        end
    endgenerate

    assign cmd_ready = gnt;
    assign count_o   = count_q;

    a_r3_queue_matches_count: assert property (@(posedge clk) disable iff (rst)
        CNT_W'(occ) == (count_q[CNT_W-1] ? (CNT_W'(0) - count_q) : CNT_W'(0)));
    a_r9_rsp_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rsp_valid));
    a_r9_rsp_follows_grant: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid != '0) |-> $past(gnt_any));

endmodule

// File: tb/csem_unit_tb.sv
module csem_unit_tb_top;

    localparam int N = 4;
    localparam int INIT = 2;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] cmd_valid = '0;
    logic [N-1:0] cmd_up = '0;
    logic [N-1:0] cmd_ready, rsp_valid;
    logic rsp_blocked, ovf_err, wake_valid;
    logic [1:0] wake_id;
    logic signed [W-1:0] count_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    csem_unit #(.N_REQ(N), .INIT_COUNT(INIT), .CNT_W(W)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_up(cmd_up),
        .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_blocked(rsp_blocked),
        .ovf_err(ovf_err), .wake_valid(wake_valid), .wake_id(wake_id),
        .count_o(count_o)
    );

    typedef struct packed {
        logic [1:0]        id;
        logic              up;
        logic              blk;
        logic              wk;
        logic [1:0]        wid;
        logic              ovf;
        logic signed [7:0] cnt;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0,  8'sd1},
        '{2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0,  8'sd0},
        '{2'd2, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, -8'sd1},
        '{2'd3, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, -8'sd2},
        '{2'd0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, -8'sd3},
        '{2'd1, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, -8'sd4},
        '{2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, -8'sd4},
        '{2'd3, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0, -8'sd3},
        '{2'd3, 1'b1, 1'b0, 1'b1, 2'd3, 1'b0, -8'sd2},
        '{2'd0, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, -8'sd1},
        '{2'd1, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0,  8'sd0},
        '{2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0,  8'sd1},
        '{2'd2, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0,  8'sd2},
        '{2'd2, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0,  8'sd3},
        '{2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0,  8'sd2}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_op(input int id, input bit up);
        @(negedge clk);
        cmd_valid = '0;
        cmd_up = '0;
        cmd_valid[id] = 1'b1;
        cmd_up[id] = up;
        @(negedge clk);
        cmd_valid = '0;
        cmd_up = '0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check(count_o == INIT, "R1", "count after reset", int'(count_o), INIT);
        check(rsp_valid == '0 && !wake_valid && !ovf_err, "R1", "strobes after reset",
              int'({rsp_valid, wake_valid, ovf_err}), 0);
        check(cmd_ready == '0, "R6", "ready with no request", int'(cmd_ready), 0);

        // Table walk: R2 R3 R4 R5 R8 R9
        for (int v = 0; v < NV; v++) begin
            string tag;
            vec_t e;
            e = VEC[v];
            if (e.ovf) tag = "R8";
            else if (e.up) tag = e.wk ? "R4" : "R5";
            else tag = e.blk ? "R3" : "R2";
            do_op(int'(e.id), e.up);
            check(rsp_valid == (4'b1 << e.id), "R9", "rsp lane", int'(rsp_valid),
                  int'(4'b1 << e.id));
            check(rsp_blocked == e.blk, tag, "blocked", int'(rsp_blocked), int'(e.blk));
            check(wake_valid == e.wk, tag, "wake", int'(wake_valid), int'(e.wk));
            if (e.wk)
                check(wake_id == e.wid, "R4", "wake id order", int'(wake_id), int'(e.wid));
            check(ovf_err == e.ovf, tag, "ovf", int'(ovf_err), int'(e.ovf));
            check(count_o == e.cnt, tag, "count", int'(count_o), int'(e.cnt));
        end

        // R4: wake is a single-cycle pulse
        @(negedge clk);
        check(!wake_valid && rsp_valid == '0, "R4", "pulse ends", int'(wake_valid), 0);

        // R7 / R6: four lanes held valid, pointer sits after lane 0
        begin
            int order [4] = '{1, 2, 3, 0};
            cmd_valid = 4'b1111;
            cmd_up = 4'b1111;
            for (int k = 0; k < 4; k++) begin
                #1;
                check(cmd_ready == (4'b1 << order[k]), "R7", "rr grant",
                      int'(cmd_ready), int'(4'b1 << order[k]));
                @(negedge clk);
                check(rsp_valid == (4'b1 << order[k]), "R9", "rr rsp lane",
                      int'(rsp_valid), int'(4'b1 << order[k]));
                cmd_valid[order[k]] = 1'b0;
                cmd_up[order[k]] = 1'b0;
            end
            check(count_o == 6, "R5", "count after four releases", int'(count_o), 6);
        end

        // R1: queue a waiter, then reset; the stale ID must never wake
        for (int k = 0; k < 7; k++) do_op(k % 3, 1'b0);
        check(count_o == -1 && rsp_blocked, "R3", "queued before reset", int'(count_o), -1);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        check(count_o == INIT, "R1", "count after mid reset", int'(count_o), INIT);
        do_op(0, 1'b0);
        do_op(1, 1'b0);
        do_op(3, 1'b0);
        check(rsp_blocked && count_o == -1, "R3", "blocked after reset", int'(count_o), -1);
        do_op(0, 1'b1);
        check(wake_valid && wake_id == 2'd3, "R1", "no stale waiter", int'(wake_id), 3);
        check(count_o == 0, "R4", "count after wake", int'(count_o), 0);

        finish_run();
    end

endmodule